// File: doc/BRIEF.md
# Link Power Status Interface Monitor

This block sits on the physical-layer side of a link-to-PHY connection. It watches the link power status signal that the link layer drives, and it sequences the shared interface through three conditions: active, reset and disabled. The status input may be held as a steady high level. It may also arrive as a train of high pulses, which is the form needed when an isolation barrier separates the two chips. Both forms count as the link being present.

The block counts consecutive low samples of the synchronised status input. When the run of low samples reaches the reset threshold, the interface drops into the reset condition and the control and data buses are held low. If the low run continues to the longer disable threshold, the interface becomes disabled and the system clock toward the link is also stopped. The clock gate changes only while the clock is low, so it cannot glitch. While the interface is disabled and no port is active, the block asks the PHY to enter low power. When the status input returns high, the block goes back to active and emits a one-cycle pulse so that a downstream initialiser can run.

Both thresholds are parameters counted in clock cycles, and DISABLE_CYC must be greater than RESET_CYC. The gap between pulses of a pulsed status input must stay below RESET_CYC cycles.

Top module: `lps_if_monitor`

## Requirements
- R1: While rst_n is low, and on the first clock edge after its release, the block is disabled: if_state = 2'b00, bus_force_low = 1, sysclk_en = 0 and init_start = 0.
- R2: lps_in passes through a two-register synchroniser. When the interface is in reset or disabled and a synchronised high sample is seen, if_state becomes 2'b10 (active) on the next edge, and init_start is 1 for exactly that one cycle.
- R3: A pulsed lps_in whose low gaps last fewer than RESET_CYC cycles keeps the interface active without interruption.
- R4: In active, once the count of consecutive synchronised low samples reaches RESET_CYC, if_state becomes 2'b01 (reset) on the next edge. In that state bus_force_low = 1 and sysclk_en stays 1.
- R5: In reset, once the low-sample count reaches DISABLE_CYC, if_state becomes 2'b00 (disabled) with sysclk_en = 0. From the second clock low phase after entry, sysclk_out stays low.
- R6: The low-sample count saturates at DISABLE_CYC. A low input of any length keeps the interface disabled.
- R7: A high status input in the reset condition returns the interface to active, with init_start as in R2.
- R8: A high status input in the disabled condition returns the interface to active, with init_start as in R2.
- R9: lowpower_req = 1 exactly when if_state is disabled and port_active = 0. It follows port_active in the same cycle.
- R10: The interface never passes from active to disabled in one step. It always passes through reset.
- R11: While active, bus_force_low = 0 and sysclk_en = 1. sysclk_out follows clk once the enable has been high for two clock low phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| lps_in | input | 1 | Link power status from the link layer, level or pulsed |
| port_active | input | 1 | High when any PHY port is active |
| if_state | output | 2 | 00 disabled, 01 reset, 10 active |
| bus_force_low | output | 1 | Hold the control and data buses low |
| sysclk_en | output | 1 | Clock enable toward the link |
| sysclk_out | output | 1 | Gated system clock toward the link |
| init_start | output | 1 | One-cycle pulse on return to active |
| lowpower_req | output | 1 | Permission for the PHY to enter low power |

## Verification
Properties checked on every cycle:
- the interface never goes from active to disabled in one step;
- init_start appears only on entry to active;
- the low-power request implies the disabled state with no port active;
- the stopped clock stays low;
- the low-sample counter never passes its saturation value.

Some behaviour is shown only by the bench's scenarios, which compare the design against a behavioural model on every clock:
- the exact edge at which the reset and disable thresholds take effect;
- that a pulsed status input keeps the interface active;
- that each return to active produces a single pulse.

// File: rtl/lps_if_pkg.sv
// Shared types for the link power status interface monitor.
package lps_if_pkg;
    typedef enum logic [1:0] {
        IF_DISABLED = 2'b00,
        IF_RESET    = 2'b01,
        IF_ACTIVE   = 2'b10
    } if_state_t;
endpackage

// File: rtl/lps_activity_det.sv
// Synchronises the link power status input and counts consecutive low
// samples. The count saturates at DISABLE_CYC.
// Assumes: lps_in is asynchronous to clk; rst_n is synchronous, active low.
module lps_activity_det #(
    parameter int DISABLE_CYC = 30,
    localparam int CNT_W = $clog2(DISABLE_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lps_in,
    output logic             lps_seen,
    output logic [CNT_W-1:0] idle_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DISABLE_CYC);

    logic sync_a;

    // Two-register synchroniser for the status input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a   <= 1'b0;
            lps_seen <= 1'b0;
        end else begin
            sync_a   <= lps_in;
            lps_seen <= sync_a;
        end
    end

    // Count low samples, restart on every high sample, stop at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= CNT_MAX;
        end else if (lps_seen) begin
            idle_cnt <= '0;
        end else if (idle_cnt < CNT_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lps_if_fsm.sv
// Interface condition sequencer: active, reset or disabled, decided from the
// low-sample count and the synchronised status. Emits init_start on each
// return to active.
// Assumes: RESET_CYC < DISABLE_CYC; idle_cnt saturates at DISABLE_CYC.
module lps_if_fsm
    import lps_if_pkg::*;
#(
    parameter int RESET_CYC   = 12,
    parameter int DISABLE_CYC = 30,
    localparam int CNT_W = $clog2(DISABLE_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lps_seen,
    input  logic [CNT_W-1:0] idle_cnt,
    output if_state_t        state,
    output logic             init_start
);
    localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(RESET_CYC);
    localparam logic [CNT_W-1:0] DIS_LIM = CNT_W'(DISABLE_CYC);

    if_state_t nxt;
    logic      wake;

    // Next-condition decision.
    always_comb begin
        nxt  = state;
        wake = 1'b0;
        case (state)
            IF_ACTIVE: begin
                if (idle_cnt >= RST_LIM) nxt = IF_RESET;
            end
            IF_RESET: begin
                if (lps_seen) begin
                    nxt  = IF_ACTIVE;
                    wake = 1'b1;
                end else if (idle_cnt >= DIS_LIM) begin
                    nxt = IF_DISABLED;
                end
            end
            default: begin
                if (lps_seen) begin
                    nxt  = IF_ACTIVE;
                    wake = 1'b1;
                end
            end
        endcase
    end

    // Condition register and the registered wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= IF_DISABLED;
            init_start <= 1'b0;
        end else begin
            state      <= nxt;
            init_start <= wake;
        end
    end
endmodule

// File: rtl/sysclk_gate.sv
// Glitch-free clock gate: the enable is captured while clk is low, and the
// output is the AND of clk and that captured enable.
// Assumes: en comes from a register clocked on the rising edge of clk.
module sysclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic gclk
);
    logic en_lo;

    // Capture the enable on the falling edge so it changes only while clk is low.
    always_ff @(negedge clk) begin
        if (!rst_n) en_lo <= 1'b0;
        else        en_lo <= en;
    end

    assign gclk = clk & en_lo;
endmodule

// File: rtl/lps_if_monitor.sv
// Top of the link power status interface monitor. Connects the activity
// detector, the condition sequencer and the clock gate, and decodes the
// bus and low-power outputs from the condition.
// Assumes: RESET_CYC < DISABLE_CYC; pulse gaps on lps_in < RESET_CYC cycles.
module lps_if_monitor
    import lps_if_pkg::*;
#(
    parameter int RESET_CYC   = 12,
    parameter int DISABLE_CYC = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lps_in,
    input  logic       port_active,
    output logic [1:0] if_state,
    output logic       bus_force_low,
    output logic       sysclk_en,
    output logic       sysclk_out,
    output logic       init_start,
    output logic       lowpower_req
);
    localparam int CNT_W = $clog2(DISABLE_CYC + 1);

    logic             lps_seen;
    logic [CNT_W-1:0] idle_cnt;
    if_state_t        state;

    lps_activity_det #(.DISABLE_CYC(DISABLE_CYC)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .lps_in   (lps_in),
        .lps_seen (lps_seen),
        .idle_cnt (idle_cnt)
    );

    lps_if_fsm #(.RESET_CYC(RESET_CYC), .DISABLE_CYC(DISABLE_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lps_seen   (lps_seen),
        .idle_cnt   (idle_cnt),
        .state      (state),
        .init_start (init_start)
    );

    sysclk_gate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sysclk_en),
        .gclk  (sysclk_out)
    );

    // Output decode from the registered condition.
    always_comb begin
        if_state      = state;
        bus_force_low = (state != IF_ACTIVE);
        sysclk_en     = (state != IF_DISABLED);
        lowpower_req  = (state == IF_DISABLED) && !port_active;
    end
endmodule

// File: rtl/lps_if_monitor_chk.sv
// Assertion checker for lps_if_monitor, attached by bind.
module lps_if_monitor_chk #(
    parameter int DISABLE_CYC = 30,
    localparam int CNT_W = $clog2(DISABLE_CYC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_active,
    input logic [1:0]       if_state,
    input logic             init_start,
    input logic             lowpower_req,
    input logic             sysclk_en,
    input logic             sysclk_out,
    input logic [CNT_W-1:0] idle_cnt
);
    assert_no_skip_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (if_state == 2'b10) |=> (if_state != 2'b00));

    assert_init_on_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> (if_state == 2'b10) && ($past(if_state) != 2'b10));

    assert_lowpower_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lowpower_req |-> (if_state == 2'b00) && !port_active);

    assert_clock_stopped_R5: assert property (@(negedge clk) disable iff (!rst_n)
        (!sysclk_en && $past(!sysclk_en)) |-> !sysclk_out);

    assert_count_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= CNT_W'(DISABLE_CYC));
endmodule

bind lps_if_monitor lps_if_monitor_chk #(.DISABLE_CYC(DISABLE_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_active  (port_active),
    .if_state     (if_state),
    .init_start   (init_start),
    .lowpower_req (lowpower_req),
    .sysclk_en    (sysclk_en),
    .sysclk_out   (sysclk_out),
    .idle_cnt     (idle_cnt)
);

// File: tb/tb_lps_if_monitor.sv
// Bench for lps_if_monitor: a behavioural model stepped on every rising
// edge and compared with the design in the middle of each low phase.
module tb_lps_if_monitor;
    localparam int RST_C = 12;
    localparam int DIS_C = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lps_in = 1'b0;
    logic port_active = 1'b0;
    logic [1:0] if_state;
    logic bus_force_low, sysclk_en, sysclk_out, init_start, lowpower_req;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    lps_if_monitor #(.RESET_CYC(RST_C), .DISABLE_CYC(DIS_C)) dut (
        .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .port_active(port_active),
        .if_state(if_state), .bus_force_low(bus_force_low), .sysclk_en(sysclk_en),
        .sysclk_out(sysclk_out), .init_start(init_start), .lowpower_req(lowpower_req)
    );

    // Behavioural model state.
    int  m_lps_q[$];
    int  m_idle = DIS_C;
    int  m_state = 0;
    bit  m_init = 0;
    int  en_hist = 0;
    int  init_cnt = 0;
    int  not_active_cnt = 0;

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Step the model on every rising edge.
    always @(posedge clk) begin
        int seen;
        int nstate;
        int nidle;
        bit ninit;
        if (!rst_n) begin
            m_lps_q = '{0, 0};
            m_idle = DIS_C;
            m_state = 0;
            m_init = 0;
        end else begin
            seen = m_lps_q[0];
            nidle = seen ? 0 : (m_idle < DIS_C ? m_idle + 1 : m_idle);
            nstate = m_state;
            ninit = 0;
            if (m_state == 2) begin
                if (m_idle >= RST_C) nstate = 1;
            end else if (seen != 0) begin
                nstate = 2;
                ninit = 1;
            end else if (m_state == 1 && m_idle >= DIS_C) begin
                nstate = 0;
            end
            void'(m_lps_q.pop_front());
            m_lps_q.push_back(int'(lps_in));
            m_idle = nidle;
            m_state = nstate;
            m_init = ninit;
        end
        en_hist = ((en_hist << 1) | (m_state != 0 ? 1 : 0)) & 3;
    end

    // Compare the design with the model in every low phase.
    always @(negedge clk) begin
        int prev_st;
        check(cur_req, int'(if_state), m_state, "if_state");
        check(cur_req, int'(bus_force_low), (m_state != 2) ? 1 : 0, "bus_force_low");
        check(cur_req, int'(sysclk_en), (m_state != 0) ? 1 : 0, "sysclk_en");
        check(cur_req, int'(init_start), int'(m_init), "init_start");
        check("R9", int'(lowpower_req), (m_state == 0 && !port_active) ? 1 : 0, "lowpower_req");
        if (rst_n && prev_st == 2 && if_state == 2'b00)
            check("R10", 1, 0, "active to disabled in one step");
        prev_st = int'(if_state);
        if (init_start) init_cnt++;
        if (if_state != 2'b10) not_active_cnt++;
    end

    // Check the gated clock while clk is high.
    always @(posedge clk) begin
        #2;
        if (rst_n && en_hist == 0) check("R5", int'(sysclk_out), 0, "sysclk_out stopped");
        if (rst_n && en_hist == 3) check("R11", int'(sysclk_out), 1, "sysclk_out running");
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        lps_in = 1'b1;
        wait_cyc(5);
        check("R1", int'(if_state), 0, "if_state in reset");
        check("R1", int'(sysclk_en), 0, "sysclk_en in reset");
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1", int'(if_state), 0, "if_state after release");

        // R2: steady high level wakes the interface once
        cur_req = "R2";
        init_cnt = 0;
        wait_cyc(20);
        check("R2", int'(if_state), 2, "active on steady level");
        check("R2", init_cnt, 1, "init_start pulses");
        check("R11", int'(bus_force_low), 0, "buses free when active");

        // R3: pulsed form keeps active
        cur_req = "R3";
        not_active_cnt = 0;
        for (int p = 0; p < 10; p++) begin
            lps_in = 1'b1; wait_cyc(2);
            lps_in = 1'b0; wait_cyc(RST_C - 3);
        end
        lps_in = 1'b1; wait_cyc(4);
        check("R3", not_active_cnt, 0, "cycles not active during pulses");

        // R4: reset threshold
        cur_req = "R4";
        lps_in = 1'b0;
        wait_cyc(RST_C + 5);
        check("R4", int'(if_state), 1, "reset state");
        check("R4", int'(sysclk_en), 1, "clock still running in reset");
        check("R4", int'(bus_force_low), 1, "buses low in reset");

        // R7: return from reset
        cur_req = "R7";
        init_cnt = 0;
        lps_in = 1'b1;
        wait_cyc(6);
        check("R7", int'(if_state), 2, "active after reset");
        check("R7", init_cnt, 1, "init_start after reset");

        // R5 and R6: disable threshold and saturation
        cur_req = "R5";
        lps_in = 1'b0;
        wait_cyc(DIS_C + 6);
        check("R5", int'(if_state), 0, "disabled state");
        check("R5", int'(sysclk_en), 0, "clock stopped");
        cur_req = "R6";
        wait_cyc(3 * DIS_C);
        check("R6", int'(if_state), 0, "still disabled after long low");

        // R9: low-power request follows port activity
        port_active = 1'b1;
        wait_cyc(2);
        check("R9", int'(lowpower_req), 0, "no low power with active port");
        port_active = 1'b0;
        wait_cyc(1);
        check("R9", int'(lowpower_req), 1, "low power when idle");

        // R8: return from disabled
        cur_req = "R8";
        init_cnt = 0;
        lps_in = 1'b1;
        wait_cyc(6);
        check("R8", int'(if_state), 2, "active after disabled");
        check("R8", init_cnt, 1, "init_start after disabled");

        // R1: hardware reset from active
        cur_req = "R1";
        rst_n = 1'b0;
        wait_cyc(3);
        check("R1", int'(if_state), 0, "reset from active");
        rst_n = 1'b1;
        wait_cyc(10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule